// File: doc/BRIEF.md
# UART Receive Character Queue

This block is the receive-side character store of a UART register model. A serial receiver, or a loopback path from the transmitter, offers 12-bit words (8 data bits and 4 status bits). Software drains them one at a time through a data-register read strobe. The head word is always visible on the read-data output.

A mode input selects between a 16-entry queue and a single holding register. The size can be changed at run time. Any change of that input empties the queue, and so does a one-cycle reset pulse.

The block keeps empty and full flags and a can-accept output for the receiver. It also raises a receive-level interrupt request on an exact match between the stored count and a trigger level of 1. A break condition reported by the line while in single-register mode is stored as a special word, and it sets a break-error flag.

Top module: `rx_char_queue`

## Requirements
- R1: Out of reset, empty_o=1, full_o=0, rx_irq_o=0, can_accept_o=1 and brk_err_o=0.
- R2: With fifo_en_i=1 the queue holds 16 words returned in arrival order. full_o rises and can_accept_o falls exactly when the 16th word is stored.
- R3: With fifo_en_i=0 the queue holds one word. full_o=1 and can_accept_o=0 after a single push.
- R4: A push while the count equals the effective depth, without a pop in the same cycle, is dropped and leaves stored words and flags unchanged.
- R5: rd_data_o shows the head word. A pop strobe always clears full_o and advances only when the queue is non-empty. empty_o is 1 exactly when the count is 0.
- R6: rx_irq_o goes to 1 when a push makes the count exactly 1. It goes to 0 on a pop that leaves the count at 0, including a pop of an empty queue. Other pops leave it unchanged.
- R7: A change of fifo_en_i empties the queue in the next cycle, returning empty_o=1 and full_o=0. rx_irq_o keeps its value. A push in that same cycle is discarded.
- R8: A one-cycle fifo_rst_i pulse empties the queue in the same way and also clears brk_err_o.
- R9: brk_i with fifo_en_i=0 stores the word 0x400 (bit 10 set) and sets brk_err_o. With fifo_en_i=1, brk_i has no effect.
- R10: A push and a pop in the same cycle are both performed. The count stays the same and the head advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Offer a received word |
| push_data_i | input | 12 | Received word: data in bits 7:0, status in bits 11:8 |
| pop_i | input | 1 | Data-register read strobe |
| brk_i | input | 1 | Break condition seen on the line |
| fifo_en_i | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| fifo_rst_i | input | 1 | One-cycle queue flush pulse |
| rd_data_o | output | 12 | Head word |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| rx_irq_o | output | 1 | Receive-level interrupt request |
| can_accept_o | output | 1 | Count is below effective depth |
| brk_err_o | output | 1 | Break stored since last flush |

## Verification
The hardest state to reach is a full queue with its read pointer away from slot 0. In that state a dropped push would overwrite the head word, so the damage is visible. The stimulus first runs a table of mixed push, pop and combined cycles, which leaves the pointer offset. It then fills all 16 slots, offers one more word, and drains the queue while checking the order. The mode-change flush is tested with an interrupt already raised, which shows that the flush leaves the interrupt alone.

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
  parameter int DEPTH   = 16,
  parameter int WIDTH   = 12,
  parameter int TRIGGER = 1,
  parameter int BRK_BIT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  input  logic             brk_i,
  input  logic             fifo_en_i,
  input  logic             fifo_rst_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             rx_irq_o,
  output logic             can_accept_o,
  output logic             brk_err_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    rd_ptr;
  logic [CW-1:0]    cnt;
  logic             en_q, full_q, irq_q, brk_q;

  wire [PW-1:0]    mask      = en_q ? PW'(DEPTH - 1) : '0;
  wire [CW-1:0]    eff_depth = en_q ? CW'(DEPTH) : CW'(1);
  wire             flush     = fifo_rst_i | (fifo_en_i != en_q);
  wire             brk_push  = brk_i & ~en_q;
  wire             wr_req    = push_i | brk_push;
  wire [WIDTH-1:0] wr_word   = brk_push ? (WIDTH'(1) << BRK_BIT) : push_data_i;
  wire             do_pop    = pop_i & (cnt != '0);
  wire [CW-1:0]    cnt_pop   = cnt - CW'(do_pop);
  wire             do_push   = wr_req & (cnt_pop < eff_depth);
  wire [CW-1:0]    cnt_nxt   = cnt_pop + CW'(do_push);
  wire [PW-1:0]    wr_slot   = (rd_ptr + PW'(cnt)) & mask;
  wire [PW-1:0]    rd_nxt    = do_pop ? ((rd_ptr + PW'(1)) & mask) : rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      cnt    <= '0;
      en_q   <= 1'b0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      en_q <= fifo_en_i;
      if (flush) begin
        rd_ptr <= '0;
        cnt    <= '0;
        full_q <= 1'b0;
        brk_q  <= 1'b0;
      end else begin
        rd_ptr <= rd_nxt;
        cnt    <= cnt_nxt;
        if (do_push && cnt_nxt == eff_depth) full_q <= 1'b1;
        else if (pop_i)                      full_q <= 1'b0;
        if (do_push && cnt_nxt == CW'(TRIGGER))                irq_q <= 1'b1;
        else if (pop_i && (cnt_pop + CW'(1)) == CW'(TRIGGER)) irq_q <= 1'b0;
        if (brk_push) brk_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!flush && do_push) mem[wr_slot] <= wr_word;
  end

  assign rd_data_o    = mem[rd_ptr];
  assign empty_o      = (cnt == '0);
  assign full_o       = full_q;
  assign rx_irq_o     = irq_q;
  assign can_accept_o = (cnt < eff_depth);
  assign brk_err_o    = brk_q;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= eff_depth);

  // R5
  full_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_o == (cnt == eff_depth));

  // R4
  drop_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !can_accept_o && !pop_i && !flush) |=> (full_o && !can_accept_o));

  // R6
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && empty_o && !pop_i && !flush) |=> rx_irq_o);

  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && (empty_o || cnt == CW'(1)) && !push_i && !brk_i && !flush) |=> !rx_irq_o);

  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty_o && !full_o && $stable(rx_irq_o)));

  // R9
  brk_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_i && en_q && fifo_en_i && !fifo_rst_i && !push_i && !pop_i) |=> $stable(cnt));
endmodule

// File: tb/rx_char_queue_tb.sv
`timescale 1ns/100ps
module rx_char_queue_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 0, pop_i = 0, brk_i = 0, fifo_en_i = 0, fifo_rst_i = 0;
  logic [11:0] push_data_i = '0;
  logic [11:0] rd_data_o;
  logic        empty_o, full_o, rx_irq_o, can_accept_o, brk_err_o;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  rx_char_queue dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .brk_i(brk_i), .fifo_en_i(fifo_en_i), .fifo_rst_i(fifo_rst_i),
    .rd_data_o(rd_data_o), .empty_o(empty_o), .full_o(full_o),
    .rx_irq_o(rx_irq_o), .can_accept_o(can_accept_o), .brk_err_o(brk_err_o));

  // {push, pop, data[11:0], exp_empty, exp_full, exp_irq, exp_head[11:0]}
  localparam logic [28:0] VEC [8] = '{
    {1'b1, 1'b0, 12'hA01, 1'b0, 1'b0, 1'b1, 12'hA01},
    {1'b1, 1'b0, 12'hB02, 1'b0, 1'b0, 1'b1, 12'hA01},
    {1'b0, 1'b1, 12'h000, 1'b0, 1'b0, 1'b1, 12'hB02},
    {1'b1, 1'b1, 12'hC03, 1'b0, 1'b0, 1'b1, 12'hC03},
    {1'b0, 1'b1, 12'h000, 1'b1, 1'b0, 1'b0, 12'h000},
    {1'b0, 1'b1, 12'h000, 1'b1, 1'b0, 1'b0, 12'h000},
    {1'b1, 1'b0, 12'hD04, 1'b0, 1'b0, 1'b1, 12'hD04},
    {1'b0, 1'b1, 12'h000, 1'b1, 1'b0, 1'b0, 12'h000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic [11:0] d, input logic r, input logic b);
    @(negedge clk);
    push_i = p; push_data_i = d; pop_i = r; brk_i = b;
    @(negedge clk);
    push_i = 0; pop_i = 0; brk_i = 0;
  endtask

  initial begin
    #20000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 empty", empty_o, 1); chk("R1 full", full_o, 0);
    chk("R1 irq", rx_irq_o, 0); chk("R1 accept", can_accept_o, 1);
    chk("R1 brk", brk_err_o, 0);

    fifo_en_i = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      step(VEC[i][28], VEC[i][26:15], VEC[i][27], 1'b0);
      chk($sformatf("R5 R6 R10 vec%0d empty", i), empty_o, VEC[i][14]);
      chk($sformatf("R5 vec%0d full", i), full_o, VEC[i][13]);
      chk($sformatf("R6 vec%0d irq", i), rx_irq_o, VEC[i][12]);
      if (!VEC[i][14]) chk($sformatf("R10 vec%0d head", i), rd_data_o, VEC[i][11:0]);
    end

    for (int i = 0; i < 16; i++) begin
      if (i == 15) chk("R2 not full at 15", full_o, 0);
      step(1'b1, 12'h100 + 12'(i), 1'b0, 1'b0);
    end
    chk("R2 full", full_o, 1); chk("R2 accept", can_accept_o, 0);
    chk("R6 irq held", rx_irq_o, 1);
    step(1'b1, 12'hFFF, 1'b0, 1'b0);
    chk("R4 full kept", full_o, 1);
    for (int i = 0; i < 16; i++) begin
      chk($sformatf("R2 R4 order %0d", i), rd_data_o, 12'h100 + 12'(i));
      step(1'b0, 12'h0, 1'b1, 1'b0);
      if (i == 0) chk("R5 full cleared", full_o, 0);
    end
    chk("R5 drained", empty_o, 1); chk("R6 irq low", rx_irq_o, 0);

    step(1'b1, 12'h011, 1'b0, 1'b0);
    step(1'b1, 12'h022, 1'b0, 1'b0);
    @(negedge clk); fifo_en_i = 1'b0;
    @(negedge clk);
    chk("R7 empty", empty_o, 1); chk("R7 full", full_o, 0);
    chk("R7 irq kept", rx_irq_o, 1); chk("R7 accept", can_accept_o, 1);

    step(1'b1, 12'h0AB, 1'b0, 1'b0);
    chk("R3 full", full_o, 1); chk("R3 accept", can_accept_o, 0);
    step(1'b1, 12'h0CD, 1'b0, 1'b0);
    chk("R4 R3 head", rd_data_o, 12'h0AB);
    step(1'b0, 12'h0, 1'b1, 1'b0);
    chk("R3 empty", empty_o, 1); chk("R6 irq clear", rx_irq_o, 0);

    step(1'b0, 12'h0, 1'b0, 1'b1);
    chk("R9 brk word", rd_data_o, 12'h400); chk("R9 brk flag", brk_err_o, 1);
    chk("R9 full", full_o, 1);
    @(negedge clk); fifo_rst_i = 1'b1;
    @(negedge clk); fifo_rst_i = 1'b0;
    chk("R8 empty", empty_o, 1); chk("R8 brk clr", brk_err_o, 0);
    chk("R8 full", full_o, 0);

    @(negedge clk); fifo_en_i = 1'b1;
    repeat (2) @(negedge clk);
    step(1'b0, 12'h0, 1'b0, 1'b1);
    chk("R9 ignored empty", empty_o, 1); chk("R9 ignored flag", brk_err_o, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule